// File: doc/BRIEF.md
# Three-Group Grayscale PWM Engine

This block produces the on/off enables for 24 constant-current channels. The channels are split into three colour groups (red, green, blue) of eight channels each. Every channel has a 12-bit brightness code. A channel stays lit for that many periods of its group's grayscale clock, so a code of 0 keeps it dark and a code of 4095 keeps it on for 4095 periods.

The whole block runs on one system clock. Each group's grayscale clock arrives as a one-cycle enable strobe and drives that group's own 13-bit counter. An active-low blank input clears all three counters, holds them at zero and forces every output off. A new 288-bit set of codes is presented in parallel on a staging input. It is copied into the active code registers on the rising edge of a latch strobe. The copy happens straight away, even in the middle of a PWM period, and the outputs follow the new codes from the next cycle.

Top module: `gs_pwm_engine`

## Requirements
- R1: After reset the active codes are all zero, and every output stays off until a latch loads a non-zero code, whatever the strobes and blank do.
- R2: A group counter steps by one only in a cycle where blank_n is high and that group's strobe bit (bit 0 red, bit 1 green, bit 2 blue) is set. A strobe for one group leaves the other groups' outputs unchanged.
- R3: While blank_n is low every output is off in the same cycle, and all three counters are cleared and held at zero even when strobes arrive.
- R4: After blank_n goes high, the first strobe of a group switches on, in the next cycle, every channel of that group with a non-zero code. A channel whose code is zero never turns on.
- R5: A channel is on while its group count is at least 1 and no greater than its code. It turns off in the cycle after the strobe that takes the count past the code, so it stays lit for exactly code strobes.
- R6: A cycle in which the latch input is high and was low in the previous cycle copies stage_word into the active codes. The outputs follow the new codes from the next cycle, in the middle of a PWM period as well. Holding the latch input high does not copy the staging input again.
- R7: A group counter stops at 4096 and does not wrap. A channel coded 4095 turns off after its 4095th strobe, and no channel of that group turns on again until blank_n is taken low and high again.
- R8: Output bit g*8+c is channel c of group g (g = 0 red, 1 green, 2 blue). Its code is stage_word[12*(g*8+c) +: 12].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank_n | input | 1 | Active-low blank: clears and holds the counters, forces outputs off |
| gclk_stb | input | 3 | Per-group grayscale clock strobes (0 red, 1 green, 2 blue) |
| latch | input | 1 | Latch strobe; its rising edge loads the staged codes |
| stage_word | input | 288 | Staged codes, 12 bits per channel |
| ch_on | output | 24 | Channel on/off enables |

## Verification
The bench gives each group a different strobe rate, so a design that shares one counter between groups, or steps every group on any strobe, produces the wrong on-times. It loads codes 0, 1, 2 and 4095, which catches an off-by-one in the compare (a channel lit one period too long or too short) and a code 0 that still flashes on. It moves the latch and blank edges into the middle of PWM periods and holds the latch input high while the staging word changes. This catches a design that only copies codes at period boundaries, one that copies on the latch level rather than its edge, and one that leaves the counters running under blank. It also runs a group past 4096 strobes, so a counter that wraps would light its channels again.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;
  parameter int GS_BITS_DEF    = 12;
  parameter int CH_PER_GRP_DEF = 8;
  parameter int NUM_GRP_DEF    = 3;
endpackage

// File: rtl/gs_latch_edge.sv
module gs_latch_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic latch,
  output logic latch_prev,
  output logic latch_rise
);
  logic prev_q, prev_d;

  always_comb prev_d = latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign latch_prev = prev_q;
  assign latch_rise = latch & ~prev_q;
endmodule

// File: rtl/gs_group_counter.sv
module gs_group_counter #(
  parameter int GS_BITS = 12,
  localparam int CW = GS_BITS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          stb,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TERM = CW'(1) << GS_BITS;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | (stb & (cnt_q != TERM));
    cnt_d  = cnt_q;
    if (clr)         cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/gs_channel_compare.sv
module gs_channel_compare #(
  parameter int GS_BITS = 12,
  parameter int NCH     = 8,
  localparam int CW = GS_BITS + 1
) (
  input  logic                 en,
  input  logic [CW-1:0]        cnt,
  input  logic [NCH*GS_BITS-1:0] codes,
  output logic [NCH-1:0]       on
);
  logic cnt_live;
  assign cnt_live = en & (cnt != '0);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] code_ext;
    assign code_ext = {1'b0, codes[i*GS_BITS +: GS_BITS]};
    assign on[i]    = cnt_live & (cnt <= code_ext);
  end
endmodule

// File: rtl/gs_code_bank.sv
module gs_code_bank #(
  parameter int W = 288
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d;

  always_comb q_d = load ? d : q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (load) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/gs_pwm_engine.sv
module gs_pwm_engine
  import gs_pwm_pkg::*;
#(
  parameter int GS_BITS    = GS_BITS_DEF,
  parameter int CH_PER_GRP = CH_PER_GRP_DEF,
  parameter int NUM_GRP    = NUM_GRP_DEF,
  localparam int NCH = CH_PER_GRP * NUM_GRP,
  localparam int SW  = NCH * GS_BITS,
  localparam int CW  = GS_BITS + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               blank_n,
  input  logic [NUM_GRP-1:0] gclk_stb,
  input  logic               latch,
  input  logic [SW-1:0]      stage_word,
  output logic [NCH-1:0]     ch_on
);
  logic              latch_prev, latch_rise;
  logic [SW-1:0]     act_codes;
  logic [NUM_GRP*CW-1:0] grp_cnt;

  gs_latch_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch      (latch),
    .latch_prev (latch_prev),
    .latch_rise (latch_rise)
  );

  gs_code_bank #(.W(SW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (latch_rise),
    .d     (stage_word),
    .q     (act_codes)
  );

  localparam int GSW = CH_PER_GRP * GS_BITS;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    gs_group_counter #(.GS_BITS(GS_BITS)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~blank_n),
      .stb   (gclk_stb[g]),
      .cnt   (grp_cnt[g*CW +: CW])
    );

    gs_channel_compare #(.GS_BITS(GS_BITS), .NCH(CH_PER_GRP)) u_cmp (
      .en    (blank_n),
      .cnt   (grp_cnt[g*CW +: CW]),
      .codes (act_codes[g*GSW +: GSW]),
      .on    (ch_on[g*CH_PER_GRP +: CH_PER_GRP])
    );
  end
endmodule

// File: rtl/gs_pwm_engine_chk.sv
module gs_pwm_engine_chk #(
  parameter int GS_BITS    = 12,
  parameter int CH_PER_GRP = 8,
  parameter int NUM_GRP    = 3,
  localparam int NCH = CH_PER_GRP * NUM_GRP,
  localparam int SW  = NCH * GS_BITS,
  localparam int CW  = GS_BITS + 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  blank_n,
  input logic [NUM_GRP-1:0]    gclk_stb,
  input logic                  latch,
  input logic                  latch_prev,
  input logic [SW-1:0]         stage_word,
  input logic [SW-1:0]         act_codes,
  input logic [NUM_GRP*CW-1:0] grp_cnt,
  input logic [NCH-1:0]        ch_on
);
  localparam logic [CW-1:0] TERM = CW'(1) << GS_BITS;

  assert_blank_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (ch_on == '0));

  assert_blank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> (grp_cnt == '0));

  assert_latch_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && !latch_prev) |=> (act_codes == $past(stage_word)));

  assert_no_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch && !latch_prev) |=> $stable(act_codes));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp_chk
    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_n && !gclk_stb[g]) |=> $stable(grp_cnt[g*CW +: CW]));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      grp_cnt[g*CW +: CW] <= TERM);

    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_n && grp_cnt[g*CW +: CW] == TERM) |=> (grp_cnt[g*CW +: CW] == TERM));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch_chk
    assert_zero_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_codes[c*GS_BITS +: GS_BITS] == '0) |-> !ch_on[c]);
  end
endmodule

bind gs_pwm_engine gs_pwm_engine_chk #(
  .GS_BITS(GS_BITS), .CH_PER_GRP(CH_PER_GRP), .NUM_GRP(NUM_GRP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .blank_n    (blank_n),
  .gclk_stb   (gclk_stb),
  .latch      (latch),
  .latch_prev (latch_prev),
  .stage_word (stage_word),
  .act_codes  (act_codes),
  .grp_cnt    (grp_cnt),
  .ch_on      (ch_on)
);

// File: tb/gs_pwm_engine_tb.sv
`timescale 1ns/1ps
module gs_pwm_engine_tb;
  logic         clk;
  logic         rst_n;
  logic         blank_n;
  logic [2:0]   gclk_stb;
  logic         latch;
  logic [287:0] stage_word;
  logic [23:0]  ch_on;

  gs_pwm_engine u_dut (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .gclk_stb(gclk_stb),
    .latch(latch), .stage_word(stage_word), .ch_on(ch_on)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference
  int          m_cnt [3];
  logic [11:0] m_code [24];
  logic        m_lat_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 3; g++) m_cnt[g] = 0;
      for (int c = 0; c < 24; c++) m_code[c] = 12'd0;
      m_lat_prev = 1'b0;
    end else begin
      for (int g = 0; g < 3; g++) begin
        if (!blank_n) m_cnt[g] = 0;
        else if (gclk_stb[g] && m_cnt[g] < 4096) m_cnt[g] = m_cnt[g] + 1;
      end
      if (latch && !m_lat_prev)
        for (int c = 0; c < 24; c++) m_code[c] = stage_word[12*c +: 12];
      m_lat_prev = latch;
    end
  end

  function automatic logic [23:0] expect_on();
    logic [23:0] e;
    for (int c = 0; c < 24; c++)
      e[c] = blank_n && (m_cnt[c/8] > 0) && (m_cnt[c/8] <= int'(m_code[c]));
    return e;
  endfunction

  int    n_vec, n_bad;
  string cur_req;
  bit    done;

  task automatic compare();
    logic [23:0] e;
    e = expect_on();
    n_vec++;
    if (ch_on !== e) begin
      n_bad++;
      $display("FAIL %s: ch_on got %h expected %h at %0t", cur_req, ch_on, e, $time);
    end
  endtask

  task automatic tick(input logic [2:0] s);
    gclk_stb = s;
    @(posedge clk);
    @(negedge clk);
    compare();
    gclk_stb = 3'b000;
  endtask

  task automatic set_code(input int ch, input logic [11:0] v);
    stage_word[12*ch +: 12] = v;
  endtask

  task automatic pulse_latch();
    latch = 1'b1;
    tick(3'b000);
    latch = 1'b0;
  endtask

  // watchdog
  int wd;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    wd = 0; n_vec = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; blank_n = 1'b1; gclk_stb = 3'b000; latch = 1'b0;
    stage_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, strobes with zero codes light nothing
    cur_req = "R1";
    compare();
    for (int i = 0; i < 10; i++) tick(3'b111);

    // R8 / R6: load a distinct pattern while blank low
    cur_req = "R3";
    blank_n = 1'b0;
    for (int c = 0; c < 8; c++) set_code(c, 12'(c));
    set_code(8, 12'd0);  set_code(9, 12'd1);  set_code(10, 12'd2);
    set_code(11, 12'd4095); set_code(12, 12'd5); set_code(13, 12'd3);
    set_code(14, 12'd7); set_code(15, 12'd10);
    for (int c = 16; c < 24; c++) set_code(c, 12'(c - 12));
    pulse_latch();
    for (int i = 0; i < 5; i++) tick(3'b111);

    // R4/R5/R2/R8: different strobe rates per group
    cur_req = "R5";
    blank_n = 1'b1;
    tick(3'b000);
    for (int i = 0; i < 30; i++)
      tick({(i % 3) == 0, (i % 2) == 0, 1'b1});

    // R2: only green strobes; red and blue hold
    cur_req = "R2";
    for (int i = 0; i < 6; i++) tick(3'b010);

    // R6: mid-period latch, then latch held high while staging changes
    cur_req = "R6";
    for (int c = 0; c < 24; c++) set_code(c, 12'd40);
    pulse_latch();
    tick(3'b111);
    set_code(3, 12'd1);
    latch = 1'b1;
    tick(3'b111);
    set_code(3, 12'd0);
    set_code(20, 12'd0);
    for (int i = 0; i < 4; i++) tick(3'b111);
    latch = 1'b0;
    tick(3'b000);

    // R3: blank drop mid run, strobes ignored
    cur_req = "R3";
    blank_n = 1'b0;
    for (int i = 0; i < 4; i++) tick(3'b111);
    cur_req = "R4";
    blank_n = 1'b1;
    tick(3'b000);
    tick(3'b001);
    tick(3'b010);
    tick(3'b100);

    // R7: saturation past 4096 strobes
    cur_req = "R7";
    blank_n = 1'b0;
    for (int c = 0; c < 24; c++) set_code(c, 12'd4095);
    set_code(0, 12'd4094); set_code(9, 12'd1);
    pulse_latch();
    blank_n = 1'b1;
    for (int i = 0; i < 4200; i++) tick(3'b111);
    for (int i = 0; i < 20; i++) tick(3'b101);
    blank_n = 1'b0;
    tick(3'b000);
    blank_n = 1'b1;
    for (int i = 0; i < 5; i++) tick(3'b111);

    // random mix
    cur_req = "R5";
    for (int i = 0; i < 20000; i++) begin
      if (($urandom % 50) == 0) latch = ~latch;
      if (($urandom % 40) == 0)
        for (int c = 0; c < 24; c++) set_code(c, 12'($urandom % 64));
      if (($urandom % 700) == 0) blank_n = 1'b0;
      else if (!blank_n && ($urandom % 4) == 0) blank_n = 1'b1;
      tick(3'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule